// File: doc/BRIEF.md
# Low-Pin-Count Bus Host Cycle Engine

This block is the host end of a four-bit multiplexed low-pin-count bus. It turns one request into a complete single-byte bus cycle toward one peripheral. A request gives the address space (memory or I/O), the direction, the address and, for a write, the data byte. When the cycle ends the block returns a one-cycle completion pulse. The pulse carries an error flag and, for a read, the byte that came back.

On the bus side the block drives an active-low frame strobe, a four-bit lane value and an enable for that lane. It reads the resolved lane state on a separate input. The lane has pull-ups, so a lane that nobody drives reads as 1111.

The host sends the start, cycle-type, address and write-data nibbles. It then releases the lane for two turnaround cycles and samples the peripheral's sync nibbles. After that it takes in any read data and waits through the return turnaround.

If the peripheral never claims the cycle, the host aborts with a soft bus reset. A new request may be accepted during the final turnaround cycle, so that the next start nibble follows with no gap.

Top module: `lpc_host_engine`

## Requirements
- R1: After reset the frame strobe is high, the lane enable is low, req_ready is high and rsp_done is low.
- R2: In the cycle after a request is accepted, the host holds the frame strobe low for exactly one cycle and drives start nibble 0000. The next cycle carries the cycle-type nibble {0, mem, write, 0}: I/O read 0000, I/O write 0010, memory read 0100, memory write 0110.
- R3: The address follows the cycle-type nibble, most significant nibble first. A memory cycle sends all 32 bits in 8 cycles. An I/O cycle sends the low 16 bits in 4 cycles.
- R4: A write sends the data byte right after the address, low nibble first. The host then leaves the lane undriven for two turnaround cycles before sync.
- R5: Sync 0000 means ready. Any sync value other than 0000, 1010 or 1111 (for example 0101 short wait or 0110 long wait) makes the host keep sampling. Up to two consecutive 1111 sync cycles are tolerated.
- R6: After a ready sync on a read, the host takes the byte from the lane over two cycles, low nibble first. Then come two undriven turnaround cycles. Completion follows with rsp_rdata equal to that byte and rsp_err low.
- R7: Sync 1010 ends the cycle without a data phase. Two turnaround cycles follow, then completion with rsp_err high.
- R8: Three consecutive 1111 sync cycles abort the cycle. The host drives the frame strobe low with the lane at 1111 for four cycles, then returns to idle and signals completion with rsp_err high.
- R9: A request presented during the final turnaround cycle is accepted there. Its start nibble appears in the very next cycle, together with the completion pulse of the previous cycle.
- R10: rsp_done is a single-cycle pulse. req_ready is high only when idle or in the final turnaround cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 32 | Target address (low 16 bits used for I/O) |
| req_wdata | input | 8 | Write data byte |
| req_ready | output | 1 | Request can be accepted this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error/abort flag, valid with rsp_done |
| rsp_rdata | output | 8 | Last byte read |
| lframe_n | output | 1 | Active-low frame strobe |
| lad_out | output | 4 | Value the host drives on the lane |
| lad_oe | output | 1 | Host lane output enable |
| lad_in | input | 4 | Resolved lane value (1111 when undriven) |

## Verification
A wrong state register shows on the lane within one cycle. The host would drive during a turnaround, or put a wrong nibble or nibble order on the lane, and the bench compares every cycle of every transfer. A wrong sync-miss count shows as an early or missing abort frame, and that appears three sync cycles after turnaround. Corrupted read capture or error latching shows on the completion pulse itself, which the bench checks in the exact cycle it should appear.

// File: rtl/lpc_host_engine.sv
module lpc_host_engine #(
  parameter int SYNC_MISS_MAX = 3,
  parameter int ABORT_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_mem,
  input  logic [31:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        req_ready,
  output logic        rsp_done,
  output logic        rsp_err,
  output logic [7:0]  rsp_rdata,
  output logic        lframe_n,
  output logic [3:0]  lad_out,
  output logic        lad_oe,
  input  logic [3:0]  lad_in
);
  localparam int CW = $clog2(ABORT_CYCLES + 8);
  localparam int MW = $clog2(SYNC_MISS_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_CTYPE, S_ADDR, S_WDATA,
    S_TARH, S_SYNC, S_RDATA, S_TARP, S_ABORT
  } state_t;

  state_t      st;
  logic [CW-1:0] cnt;
  logic [MW-1:0] miss;
  logic        mem_q, wr_q, err_q;
  logic [31:0] addr_q;
  logic [7:0]  wd_q;
  logic [3:0]  rd_lo;
  logic        accept;

  assign req_ready = (st == S_IDLE) || (st == S_TARP && cnt == CW'(1));
  assign accept    = req_valid && req_ready;
  assign lframe_n  = !(st == S_START || st == S_ABORT);
  assign lad_oe    = st inside {S_START, S_CTYPE, S_ADDR, S_WDATA, S_ABORT};

  always_comb begin
    case (st)
      S_START: lad_out = 4'h0;
      S_CTYPE: lad_out = {1'b0, mem_q, wr_q, 1'b0};
      S_ADDR:  lad_out = addr_q[{cnt[2:0], 2'b00} +: 4];
      S_WDATA: lad_out = cnt[0] ? wd_q[7:4] : wd_q[3:0];
      default: lad_out = 4'hF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept) begin
      mem_q  <= req_mem;
      wr_q   <= req_write;
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      miss      <= '0;
      err_q     <= 1'b0;
      rd_lo     <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      case (st)
        S_IDLE: if (accept) st <= S_START;
        S_START: begin
          st    <= S_CTYPE;
          err_q <= 1'b0;
        end
        S_CTYPE: begin
          st  <= S_ADDR;
          cnt <= mem_q ? CW'(7) : CW'(3);
        end
        S_ADDR:
          if (cnt == '0) st <= wr_q ? S_WDATA : S_TARH;
          else           cnt <= cnt - CW'(1);
        S_WDATA:
          if (cnt == CW'(1)) begin st <= S_TARH; cnt <= '0; end
          else               cnt <= CW'(1);
        S_TARH:
          if (cnt == CW'(1)) begin st <= S_SYNC; cnt <= '0; miss <= '0; end
          else               cnt <= CW'(1);
        S_SYNC:
          case (lad_in)
            4'h0: st <= wr_q ? S_TARP : S_RDATA;
            4'hA: begin st <= S_TARP; err_q <= 1'b1; end
            4'hF:
              if (miss == MW'(SYNC_MISS_MAX - 1)) st <= S_ABORT;
              else                                miss <= miss + MW'(1);
            default: miss <= '0;
          endcase
        S_RDATA:
          if (cnt == CW'(1)) begin
            rsp_rdata <= {lad_in, rd_lo};
            st  <= S_TARP;
            cnt <= '0;
          end else begin
            rd_lo <= lad_in;
            cnt   <= CW'(1);
          end
        S_TARP:
          if (cnt == CW'(1)) begin
            rsp_done <= 1'b1;
            rsp_err  <= err_q;
            cnt      <= '0;
            st       <= accept ? S_START : S_IDLE;
          end else cnt <= CW'(1);
        S_ABORT:
          if (cnt == CW'(ABORT_CYCLES - 1)) begin
            rsp_done <= 1'b1;
            rsp_err  <= 1'b1;
            cnt      <= '0;
            st       <= S_IDLE;
          end else cnt <= cnt + CW'(1);
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module lpc_host_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_done,
  input logic       rsp_err,
  input logic       lframe_n,
  input logic [3:0] lad_out,
  input logic       lad_oe
);
  p_frame_drives_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> lad_oe);
  p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lframe_n) && lad_out == 4'h0) |=> lframe_n);
  p_turnaround_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lad_oe) && $past(lframe_n)) |=> !lad_oe);
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);
  p_abort_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lframe_n) && lad_out == 4'hF) |=> (!lframe_n && lad_out == 4'hF));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_no_ready_framed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> !req_ready);
endmodule

bind lpc_host_engine lpc_host_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .rsp_err(rsp_err), .lframe_n(lframe_n), .lad_out(lad_out), .lad_oe(lad_oe)
);

// File: tb/lpc_host_engine_tb.sv
module lpc_host_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_mem = 0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done, rsp_err, lframe_n, lad_oe;
  logic [7:0] rsp_rdata;
  logic [3:0] lad_out, lad_in;
  logic per_oe = 0;
  logic [3:0] per_out = 4'hF;
  int checks = 0, errors = 0;
  bit nx_mem, nx_wr;
  logic [31:0] nx_addr;
  logic [7:0] nx_wd;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign lad_in = lad_oe ? lad_out : (per_oe ? per_out : 4'hF);

  lpc_host_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mem(req_mem), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .lframe_n(lframe_n), .lad_out(lad_out),
    .lad_oe(lad_oe), .lad_in(lad_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input bit mem, input bit wr, input logic [31:0] addr, input logic [7:0] wd);
    req_valid = 1; req_mem = mem; req_write = wr; req_addr = addr; req_wdata = wd;
  endtask

  // kind: 0 ready, 1 error sync, 2 no claim (abort)
  task automatic xfer(input bit mem, input bit wr, input logic [31:0] addr, input logic [7:0] wd,
                      input logic [7:0] rdv, input int nsil, input int nwait, input int kind,
                      input bit pre, input bit chain);
    int na = mem ? 8 : 4;
    if (!pre) begin
      @(negedge clk); issue(mem, wr, addr, wd);
      chk(req_ready, "R10 ready idle", {31'd0, req_ready}, 1);
    end
    @(negedge clk); req_valid = 0;
    if (pre) chk(rsp_done, "R9 done with next start", {31'd0, rsp_done}, 1);
    chk(!lframe_n && lad_oe && lad_out == 4'h0, "R2 start", {27'd0, lframe_n, lad_out}, 0);
    @(negedge clk);
    chk(lframe_n && lad_out == {1'b0, mem, wr, 1'b0}, "R2 ctype", {27'd0, lframe_n, lad_out},
        {27'd0, 1'b1, 1'b0, mem, wr, 1'b0});
    for (int i = 0; i < na; i++) begin
      @(negedge clk);
      chk(lad_oe && lad_out == addr[4*(na-1-i) +: 4], "R3 address nibble", {28'd0, lad_out},
          {28'd0, addr[4*(na-1-i) +: 4]});
    end
    if (wr) for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(lad_oe && lad_out == wd[4*i +: 4], "R4 write nibble", {28'd0, lad_out}, {28'd0, wd[4*i +: 4]});
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!lad_oe && !req_ready, "R4 turnaround undriven", {30'd0, lad_oe, req_ready}, 0);
    end
    if (kind == 2) begin
      for (int i = 0; i < 3; i++) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(!lframe_n && lad_oe && lad_out == 4'hF, "R8 abort frame", {26'd0, lframe_n, lad_oe, lad_out}, 32'h1F);
      end
      @(negedge clk);
      chk(rsp_done && rsp_err && lframe_n && req_ready, "R8 abort done", {28'd0, rsp_done, rsp_err, lframe_n, req_ready}, 32'hF);
      @(negedge clk);
      chk(!rsp_done, "R10 done pulse", {31'd0, rsp_done}, 0);
      return;
    end
    for (int i = 0; i < nsil; i++) @(negedge clk);
    for (int i = 0; i < nwait; i++) begin
      @(negedge clk); per_oe = 1;
      per_out = (i % 3 == 0) ? 4'h5 : (i % 3 == 1) ? 4'h6 : 4'h3;
      chk(lframe_n && !lad_oe, "R5 waiting", {30'd0, lframe_n, lad_oe}, 2);
    end
    @(negedge clk); per_oe = 1; per_out = (kind == 1) ? 4'hA : 4'h0;
    chk(lframe_n && !lad_oe, "R5 sync no abort", {30'd0, lframe_n, lad_oe}, 2);
    if (kind == 0 && !wr) begin
      @(negedge clk); per_out = rdv[3:0];
      @(negedge clk); per_out = rdv[7:4];
    end
    @(negedge clk); per_out = 4'hF;
    chk(!lad_oe && !rsp_done, "R6 return turnaround", {30'd0, lad_oe, rsp_done}, 0);
    @(negedge clk); per_oe = 0;
    chk(!lad_oe && req_ready, "R9 ready in last turnaround", {30'd0, lad_oe, req_ready}, 1);
    if (chain) begin
      issue(nx_mem, nx_wr, nx_addr, nx_wd);
      return;
    end
    @(negedge clk);
    chk(rsp_done && rsp_err == (kind == 1), "R7 done/err", {30'd0, rsp_done, rsp_err}, {30'd0, 1'b1, kind == 1});
    if (kind == 0 && !wr)
      chk(rsp_rdata == rdv, "R6 read data", {24'd0, rsp_rdata}, {24'd0, rdv});
    @(negedge clk);
    chk(!rsp_done, "R10 done pulse", {31'd0, rsp_done}, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(lframe_n && !lad_oe && req_ready && !rsp_done, "R1 reset state",
        {28'd0, lframe_n, lad_oe, req_ready, rsp_done}, 32'hA);
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 3; k++)
          for (int s = 0; s < 3; s++) begin
            if (k == 2 && s > 0) continue;
            xfer(m[0], w[0], 32'hA5C3_0F1E + idx * 32'h1111_1111, 8'h3C + 8'(idx * 7),
                 8'hC5 ^ 8'(idx * 13), s, idx % 4, k, 0, 0);
            idx++;
          end
    nx_mem = 1; nx_wr = 0; nx_addr = 32'h8765_4321; nx_wd = 8'h00;
    xfer(0, 1, 32'h0000_BEEF, 8'h5A, 8'h00, 1, 1, 0, 0, 1);
    xfer(1, 0, 32'h8765_4321, 8'h00, 8'h9D, 2, 2, 0, 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule